// File: doc/BRIEF.md
# Dual-converter channel pair scheduler

This block plans the work of two sampling converters, A and B, which run in lock step and share one conversion slot timer. It has two scheduling modes. In pair mode, a channel mask picks auxiliary pairs. Each pair starts converter A on auxiliary input n and converter B on auxiliary input n+8 at the same moment, so the phase relationship between the two signals is kept. Internal-sensor slots can be mixed into the pass. In those slots only converter A converts.

In split mode, converter A runs a fixed background loop over the internal sensors with alarm checking, which needs no configuration. Converter B walks a user mask of external inputs: the dedicated input pair and then auxiliary inputs 0 to 15. Both converters take their slot timing from the same source. With event timing, each slot waits for a conversion-start strobe, so if the strobe stops, the background monitoring on converter A also stops. Each finished slot gives one result-update strobe. The channel address and valid flag of each converter are presented with that strobe and held until the next one.

Top module: `pair_sched`

## Requirements
- R1: During and right after reset, `result_upd`, `a_valid` and `b_valid` are low and both channel addresses are 0.
- R2: In pair mode (`indep_mode`=0), `aux_sel` bit n (n = 0..7) gives one update in which `a_chan`=16+n and `b_chan`=24+n, both valid. Pairs are issued in ascending n.
- R3: In pair mode, `aux_sel` bits 8 to 15 have no effect on the updates produced.
- R4: In pair mode, `sensor_sel` bits 0, 1, 2 and 6 add internal-sensor slots. In these slots `a_chan` equals the bit index, `b_valid` is low, and the slots come before the pairs in each pass. Other `sensor_sel` bits are ignored in pair mode.
- R5: With continuous timing, successive updates are CONV_CYC cycles apart. A slot for pair n whose `settle_sel` bit n is set, or for split-mode auxiliary input n with bit n set, is SETTLE_CYC cycles longer.
- R6: The calibration address 8 is never issued on either converter.
- R7: In split mode (`indep_mode`=1), converter B issues channel 3 if `sensor_sel` bit 11 is set, then `aux_sel` bits 0..15 as channels 16..31 in ascending order. No other `sensor_sel` bit affects converter B.
- R8: In split mode, every update has `a_valid` high, and `a_chan` cycles through 0, 1, 2, 6 regardless of the masks.
- R9: In split mode with no converter-B channel enabled, updates continue with `b_valid` low while converter A keeps cycling.
- R10: With event timing (`event_timing`=1), a slot starts only on a `conv_start` pulse while no slot is in progress. A pulse during a slot is ignored. Without pulses, no update occurs in either mode.
- R11: With continuous timing, after the last enabled entry the sequence wraps to the first enabled entry.
- R12: A change of `indep_mode` or `event_timing` abandons the slot in progress and restarts the sequence at its first entry.
- R13: In pair mode with no enabled entry, no update occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| indep_mode | input | 1 | 0 = pair mode, 1 = split mode |
| event_timing | input | 1 | 1 = slots wait for conv_start, 0 = back-to-back slots |
| conv_start | input | 1 | Conversion-start strobe for event timing |
| sensor_sel | input | 16 | Internal-sensor and dedicated-input mask |
| aux_sel | input | 16 | Auxiliary input / pair mask |
| settle_sel | input | 16 | Per-pair (or per-input) extra settling enable |
| a_chan | output | 5 | Converter A channel address of the latest update |
| a_valid | output | 1 | Converter A converted in the latest update |
| b_chan | output | 5 | Converter B channel address of the latest update |
| b_valid | output | 1 | Converter B converted in the latest update |
| result_upd | output | 1 | One-cycle strobe: both results updated |

## Verification
The assertions judge each update against the mode seen one cycle earlier. This relies on a mode change never being followed on the next edge by an update from the old mode, which the restart rule guarantees. They also assume CONV_CYC is at least 2, so update strobes are never adjacent. The stimulus sets the masks while reset is held, or changes the mode one cycle after a clock edge. Strobes are single-cycle pulses driven between edges, so every update belongs to exactly one configuration.

// File: rtl/pair_sched_pkg.sv
package pair_sched_pkg;

  localparam int CH_W      = 5;
  localparam int NPAIR     = 8;
  localparam int NAUX      = 16;
  localparam int SENS_N    = 4;
  localparam int AUX_BASE  = 16;
  localparam int PAIR_OFS  = 8;
  localparam int DED_ADDR  = 3;
  localparam int DED_BIT   = 11;

  typedef struct packed {
    logic            a_vld;
    logic [CH_W-1:0] a_chan;
    logic            b_vld;
    logic [CH_W-1:0] b_chan;
    logic            settle;
  } slot_t;

  // internal sensor addresses in scan order
  function automatic int sens_addr(input int k);
    case (k)
      0:       return 0;
      1:       return 1;
      2:       return 2;
      default: return 6;
    endcase
  endfunction

endpackage

// File: rtl/sched_find.sv
module sched_find #(
  parameter int N  = 12,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  en,
  input  logic [IW-1:0] start,
  output logic          hit,
  output logic [IW-1:0] idx
);
  logic          lo_hit;
  logic [IW-1:0] lo_idx;

  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    lo_hit = 1'b0;
    lo_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (en[i]) begin
        lo_hit = 1'b1;
        lo_idx = IW'(i);
        if (i >= int'(start)) begin
          hit = 1'b1;
          idx = IW'(i);
        end
      end
    end
    if (!hit) begin
      hit = lo_hit;
      idx = lo_idx;
    end
  end
endmodule

// File: rtl/sched_timer.sv
module sched_timer #(
  parameter int CONV_CYC   = 4,
  parameter int SETTLE_CYC = 10,
  localparam int CNT_W     = $clog2(CONV_CYC + SETTLE_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic settle,
  output logic zero
);
  localparam logic [CNT_W-1:0] BASE = CNT_W'(CONV_CYC - 2);
  localparam logic [CNT_W-1:0] LONG = CNT_W'(CONV_CYC - 2 + SETTLE_CYC);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= settle ? LONG : BASE;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sched_slot_map.sv
module sched_slot_map
  import pair_sched_pkg::*;
#(
  parameter int SIM_IW = 4,
  parameter int IND_IW = 5,
  parameter int ROT_W  = 2
) (
  input  logic              indep,
  input  logic [SIM_IW-1:0] sim_idx,
  input  logic              ind_hit,
  input  logic [IND_IW-1:0] ind_idx,
  input  logic [ROT_W-1:0]  rotor,
  input  logic [NAUX-1:0]   settle_sel,
  output slot_t             slot
);
  logic [CH_W-1:0] pair_n;
  logic [CH_W-1:0] aux_n;

  always_comb begin
    pair_n = CH_W'(sim_idx) - CH_W'(SENS_N);
    aux_n  = CH_W'(ind_idx) - CH_W'(1);
    slot   = '0;
    if (!indep) begin
      if (int'(sim_idx) < SENS_N) begin
        slot.a_vld  = 1'b1;
        slot.a_chan = CH_W'(sens_addr(int'(sim_idx)));
      end else begin
        slot.a_vld  = 1'b1;
        slot.a_chan = CH_W'(AUX_BASE) + pair_n;
        slot.b_vld  = 1'b1;
        slot.b_chan = CH_W'(AUX_BASE + PAIR_OFS) + pair_n;
        slot.settle = settle_sel[pair_n[3:0]];
      end
    end else begin
      slot.a_vld  = 1'b1;
      slot.a_chan = CH_W'(sens_addr(int'(rotor)));
      slot.b_vld  = ind_hit;
      if (ind_hit) begin
        if (ind_idx == '0) begin
          slot.b_chan = CH_W'(DED_ADDR);
        end else begin
          slot.b_chan = CH_W'(AUX_BASE) + aux_n;
          slot.settle = settle_sel[aux_n[3:0]];
        end
      end
    end
  end
endmodule

// File: rtl/pair_sched.sv
module pair_sched
  import pair_sched_pkg::*;
#(
  parameter int CONV_CYC   = 4,
  parameter int SETTLE_CYC = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            indep_mode,
  input  logic            event_timing,
  input  logic            conv_start,
  input  logic [15:0]     sensor_sel,
  input  logic [15:0]     aux_sel,
  input  logic [15:0]     settle_sel,
  output logic [CH_W-1:0] a_chan,
  output logic            a_valid,
  output logic [CH_W-1:0] b_chan,
  output logic            b_valid,
  output logic            result_upd
);
  localparam int SIM_N  = SENS_N + NPAIR;
  localparam int IND_N  = 1 + NAUX;
  localparam int SIM_IW = $clog2(SIM_N);
  localparam int IND_IW = $clog2(IND_N);
  localparam int ROT_W  = $clog2(SENS_N);

  typedef enum logic {ST_IDLE, ST_BUSY} st_t;

  st_t               state;
  logic [IND_IW-1:0] ptr, pend_ptr;
  logic [ROT_W-1:0]  rotor;
  logic              mode_q, evt_q;
  slot_t             pend, slot;

  logic [SIM_N-1:0]  en_sim;
  logic [IND_N-1:0]  en_ind;
  logic              sim_hit, ind_hit;
  logic [SIM_IW-1:0] sim_idx;
  logic [IND_IW-1:0] ind_idx;
  logic [IND_IW-1:0] nxt_ptr;
  logic              restart, go, can, pick, tmr_zero;

  // enable vectors
  for (genvar k = 0; k < SENS_N; k++) begin : g_sens
    assign en_sim[k] = sensor_sel[sens_addr(k)];
  end
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign en_sim[SENS_N + p] = aux_sel[p];
  end
  assign en_ind[0] = sensor_sel[DED_BIT];
  for (genvar q = 0; q < NAUX; q++) begin : g_aux
    assign en_ind[1 + q] = aux_sel[q];
  end

  sched_find #(.N(SIM_N), .IW(SIM_IW)) u_find_sim (
    .en(en_sim), .start(ptr[SIM_IW-1:0]), .hit(sim_hit), .idx(sim_idx)
  );

  sched_find #(.N(IND_N), .IW(IND_IW)) u_find_ind (
    .en(en_ind), .start(ptr), .hit(ind_hit), .idx(ind_idx)
  );

  sched_slot_map #(.SIM_IW(SIM_IW), .IND_IW(IND_IW), .ROT_W(ROT_W)) u_map (
    .indep(indep_mode), .sim_idx(sim_idx), .ind_hit(ind_hit),
    .ind_idx(ind_idx), .rotor(rotor), .settle_sel(settle_sel), .slot(slot)
  );

  always_comb begin
    if (!indep_mode)
      nxt_ptr = (int'(sim_idx) == SIM_N - 1) ? '0 : IND_IW'(sim_idx) + 1'b1;
    else if (!ind_hit)
      nxt_ptr = '0;
    else
      nxt_ptr = (int'(ind_idx) == IND_N - 1) ? '0 : ind_idx + 1'b1;
  end

  assign restart = (indep_mode != mode_q) || (event_timing != evt_q);
  assign go      = !event_timing || conv_start;
  assign can     = indep_mode || sim_hit;
  assign pick    = !restart && (state == ST_IDLE) && go && can;

  sched_timer #(.CONV_CYC(CONV_CYC), .SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .load(pick), .settle(slot.settle), .zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      ptr        <= '0;
      pend_ptr   <= '0;
      rotor      <= '0;
      pend       <= '0;
      mode_q     <= indep_mode;
      evt_q      <= event_timing;
      a_chan     <= '0;
      a_valid    <= 1'b0;
      b_chan     <= '0;
      b_valid    <= 1'b0;
      result_upd <= 1'b0;
    end else begin
      result_upd <= 1'b0;
      mode_q     <= indep_mode;
      evt_q      <= event_timing;
      if (restart) begin
        state <= ST_IDLE;
        ptr   <= '0;
        rotor <= '0;
      end else begin
        case (state)
          ST_IDLE: begin
            if (pick) begin
              pend     <= slot;
              pend_ptr <= nxt_ptr;
              state    <= ST_BUSY;
            end
          end
          ST_BUSY: begin
            if (tmr_zero) begin
              result_upd <= 1'b1;
              a_chan     <= pend.a_chan;
              a_valid    <= pend.a_vld;
              b_chan     <= pend.b_chan;
              b_valid    <= pend.b_vld;
              ptr        <= pend_ptr;
              if (indep_mode)
                rotor <= (int'(rotor) == SENS_N - 1) ? '0 : rotor + 1'b1;
              state <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/pair_sched_chk.sv
module pair_sched_chk
  import pair_sched_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            indep_mode,
  input logic [CH_W-1:0] a_chan,
  input logic            a_valid,
  input logic [CH_W-1:0] b_chan,
  input logic            b_valid,
  input logic            result_upd
);
  AST_PAIR_LOCK: assert property (@(posedge clk) disable iff (rst)
    (result_upd && b_valid && !$past(indep_mode)) |-> (a_valid && b_chan == a_chan + 5'd8)); // R2

  AST_PAIR_RANGE: assert property (@(posedge clk) disable iff (rst)
    (result_upd && b_valid && !$past(indep_mode)) |-> (b_chan >= 5'd24)); // R3

  AST_SENSOR_B_IDLE: assert property (@(posedge clk) disable iff (rst)
    (result_upd && !$past(indep_mode) && a_chan < 5'd16) |-> !b_valid); // R4

  AST_NO_CAL: assert property (@(posedge clk) disable iff (rst)
    result_upd |-> (!(a_valid && a_chan == 5'd8) && !(b_valid && b_chan == 5'd8))); // R6

  AST_SPLIT_B_EXT: assert property (@(posedge clk) disable iff (rst)
    (result_upd && $past(indep_mode) && b_valid) |-> (b_chan == 5'd3 || b_chan >= 5'd16)); // R7

  AST_SPLIT_A_SENSOR: assert property (@(posedge clk) disable iff (rst)
    (result_upd && $past(indep_mode)) |-> (a_valid && a_chan < 5'd16)); // R8

  AST_UPD_PULSE: assert property (@(posedge clk) disable iff (rst)
    result_upd |=> !result_upd); // R5
endmodule

bind pair_sched pair_sched_chk u_chk (
  .clk(clk), .rst(rst), .indep_mode(indep_mode), .a_chan(a_chan),
  .a_valid(a_valid), .b_chan(b_chan), .b_valid(b_valid), .result_upd(result_upd)
);

// File: tb/tb_pair_sched.sv
`timescale 1ns/1ps
module tb_pair_sched;
  localparam int CONV   = 4;
  localparam int SETTLE = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic indep_mode = 1'b0, event_timing = 1'b0, conv_start = 1'b0;
  logic [15:0] sensor_sel = '0, aux_sel = '0, settle_sel = '0;
  logic [4:0] a_chan, b_chan;
  logic a_valid, b_valid, result_upd;

  pair_sched #(.CONV_CYC(CONV), .SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst(rst), .indep_mode(indep_mode), .event_timing(event_timing),
    .conv_start(conv_start), .sensor_sel(sensor_sel), .aux_sel(aux_sel),
    .settle_sel(settle_sel), .a_chan(a_chan), .a_valid(a_valid),
    .b_chan(b_chan), .b_valid(b_valid), .result_upd(result_upd)
  );

  always #2.5 clk = ~clk;

  int vectors = 0, miscomp = 0, cyc = 0, rec_n = 0;
  int rec_a[64], rec_b[64], rec_av[64], rec_bv[64], rec_t[64];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (result_upd && rec_n < 64) begin
      rec_a[rec_n]  = a_chan;
      rec_b[rec_n]  = b_chan;
      rec_av[rec_n] = a_valid;
      rec_bv[rec_n] = b_valid;
      rec_t[rec_n]  = cyc;
      rec_n = rec_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscomp++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic setup(input logic m, input logic ev, input logic [15:0] s,
                       input logic [15:0] a, input logic [15:0] st);
    @(posedge clk); #1;
    rst = 1'b1; indep_mode = m; event_timing = ev; conv_start = 1'b0;
    sensor_sel = s; aux_sel = a; settle_sel = st;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    rec_n = 0;
  endtask

  task automatic collect(input string tag, input int n);
    int waited = 0;
    while (rec_n < n && waited < 2000) begin
      @(posedge clk);
      waited++;
    end
    @(negedge clk);
    if (rec_n < n) chk(tag, rec_n, n);
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 conv_start = 1'b1;
    @(posedge clk); #1 conv_start = 1'b0;
  endtask

  task automatic t_reset();
    setup(1'b0, 1'b0, 16'h0000, 16'h00FF, 16'h0000);
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk);
    chk("R1 upd", result_upd, 0);
    chk("R1 a_valid", a_valid, 0);
    chk("R1 b_valid", b_valid, 0);
    chk("R1 a_chan", a_chan, 0);
    chk("R1 b_chan", b_chan, 0);
    @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 after release upd", result_upd, 0);
  endtask

  task automatic t_pairs();
    int pn[4] = '{0, 2, 5, 0};
    setup(1'b0, 1'b0, 16'h0000, 16'hFF25, 16'h0000);
    collect("R2 count", 4);
    for (int k = 0; k < 4; k++) begin
      chk("R2 a_chan", rec_a[k], 16 + pn[k]);
      chk("R2 b_chan", rec_b[k], 24 + pn[k]);
      chk("R3 a_valid", rec_av[k], 1);
      chk("R2 b_valid", rec_bv[k], 1);
    end
    chk("R11 wrap to pair 0", rec_a[3], 16);
    chk("R5 plain spacing", rec_t[2] - rec_t[1], CONV);
  endtask

  task automatic t_sensors();
    int ea[4] = '{0, 6, 17, 0};
    int eb[4] = '{0, 0, 1, 0};
    setup(1'b0, 1'b0, 16'h0849, 16'h0002, 16'h0000);
    collect("R4 count", 4);
    for (int k = 0; k < 4; k++) begin
      chk("R4 a_chan", rec_a[k], ea[k]);
      chk("R4 b_valid", rec_bv[k], eb[k]);
    end
    chk("R4 pair b_chan", rec_b[2], 25);
  endtask

  task automatic t_settle();
    setup(1'b0, 1'b0, 16'h0000, 16'h0003, 16'h0002);
    collect("R5 count", 4);
    chk("R5 settled pair1", rec_t[1] - rec_t[0], CONV + SETTLE);
    chk("R5 plain pair0", rec_t[2] - rec_t[1], CONV);
    chk("R5 settled again", rec_t[3] - rec_t[2], CONV + SETTLE);
    for (int k = 0; k < 4; k++) chk("R6 no calibration", int'(rec_a[k] == 8), 0);
  endtask

  task automatic t_split();
    int eb[5] = '{3, 16, 31, 3, 16};
    int ea[5] = '{0, 1, 2, 6, 0};
    setup(1'b1, 1'b0, 16'h0847, 16'h8001, 16'h0000);
    collect("R7 count", 5);
    for (int k = 0; k < 5; k++) begin
      chk("R7 b_chan", rec_b[k], eb[k]);
      chk("R7 b_valid", rec_bv[k], 1);
      chk("R8 a_chan", rec_a[k], ea[k]);
      chk("R8 a_valid", rec_av[k], 1);
    end
  endtask

  task automatic t_split_settle();
    setup(1'b1, 1'b0, 16'h0000, 16'h0006, 16'h0004);
    collect("R5 split count", 3);
    chk("R5 split settled aux2", rec_t[1] - rec_t[0], CONV + SETTLE);
    chk("R5 split aux1 plain", rec_t[2] - rec_t[1], CONV);
  endtask

  task automatic t_split_empty();
    int ea[4] = '{0, 1, 2, 6};
    setup(1'b1, 1'b0, 16'h0000, 16'h0000, 16'h0000);
    collect("R9 count", 4);
    for (int k = 0; k < 4; k++) begin
      chk("R9 b_valid low", rec_bv[k], 0);
      chk("R9 a_chan", rec_a[k], ea[k]);
    end
  endtask

  task automatic t_empty_pair();
    setup(1'b0, 1'b0, 16'h0800, 16'hFF00, 16'h0000);
    repeat (100) @(posedge clk);
    @(negedge clk);
    chk("R13 no updates", rec_n, 0);
  endtask

  task automatic t_event();
    setup(1'b0, 1'b1, 16'h0000, 16'h0001, 16'h0000);
    repeat (50) @(posedge clk);
    @(negedge clk);
    chk("R10 idle without strobe", rec_n, 0);
    pulse_start();
    pulse_start();
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R10 one update for two close strobes", rec_n, 1);
    chk("R10 pair 0", rec_a[0], 16);
    pulse_start();
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk("R10 second strobe", rec_n, 2);
    setup(1'b1, 1'b1, 16'h0000, 16'h0001, 16'h0000);
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R10 split monitoring halts", rec_n, 0);
  endtask

  task automatic t_restart();
    setup(1'b0, 1'b0, 16'h0000, 16'h00FF, 16'h0000);
    collect("R12 warmup", 3);
    @(posedge clk); #1 indep_mode = 1'b1;
    @(negedge clk); rec_n = 0;
    collect("R12 split count", 2);
    chk("R12 split B first", rec_b[0], 16);
    chk("R12 split A first", rec_a[0], 0);
    @(posedge clk); #1 indep_mode = 1'b0;
    @(negedge clk); rec_n = 0;
    collect("R12 pair count", 1);
    chk("R12 pair restarts at 0", rec_a[0], 16);
  endtask

  initial begin
    t_reset();
    t_pairs();
    t_sensors();
    t_settle();
    t_split();
    t_split_settle();
    t_split_empty();
    t_empty_pair();
    t_event();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    miscomp++;
    vectors++;
    $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule